// File: doc/BRIEF.md
# Delay-Line Frequency Discriminator for Oscillator Stabilisation

This block produces the correction signal for an oscillator held on frequency by digital feedback. The oscillator under control is the module clock. A binary divider of programmable length turns it into a sample strobe that fires once every M = 2^DIV_STAGES clocks. On each strobe, a square-wave reference brought in asynchronously is latched into the newest stage of a short history register. The sample in that stage is then compared with the sample taken DLY strobes earlier.

When the two samples differ, the correction tells the oscillator to move one way. When they match, it tells it to move the other way. The comparison spans DLY sample periods, so corrections arrive DLY times more often than with a single-flop comparator for the same frequency step. The step between lock points is roughly f_osc² / (DLY · M · f_ref).

Each correction is given in three forms:
- the raw correction bit;
- a one-clock raise or lower pulse;
- a saturating signed control word that integrates the pulses, for use by a digital tuning element.

Top module: `fast_lock_discriminator`

## Requirements
- R1: With reset released before rising edge 1, the strobe fires at rising edges M, 2M, 3M and so on, where M = 2^DIV_STAGES. Exactly one correction pulse follows each valid strobe, at the next edge.
- R2: The sample stored at strobe edge e is the reference level that was present at edge e−2. The reference passes through SYNC_STAGES = 2 synchroniser flops, and these are not counted in DLY.
- R3: At the edge after strobe number j, corr_bit takes the value sample[j] XOR sample[j−DLY]. It keeps that value until the next valid comparison.
- R4: corr_valid stays 0 until DLY+1 strobes have completed after reset, then stays 1. While it is 0, corr_bit stays 0, no pulse appears and ctrl_word does not change.
- R5: For each valid comparison, exactly one of up_pulse or down_pulse is high for one clock. up_pulse means a correction bit of 1, and down_pulse means a correction bit of 0.
- R6: ctrl_word is a two's-complement value of CW bits. It rises by 1 on up_pulse and falls by 1 on down_pulse. It saturates at 2^(CW−1)−1 and at −2^(CW−1).
- R7: Reset is synchronous and active high. It clears ctrl_word to 0 (mid-scale), clears corr_bit, corr_valid and both pulses, and clears the history and synchroniser stages to 0.
- R8: A lock point is a reference whose period divides DLY·M clocks a whole number of times. At a lock point, every valid correction bit is 0. When the quotient is a whole number plus one half, every valid correction bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controlled oscillator output, used as the module clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous square-wave reference |
| corr_bit | output | 1 | Latest correction bit: 1 when the two samples differ |
| corr_valid | output | 1 | High once the history holds DLY+1 post-reset samples |
| up_pulse | output | 1 | One-clock pulse for a correction bit of 1 |
| down_pulse | output | 1 | One-clock pulse for a correction bit of 0 |
| ctrl_word | output | CW | Saturating two's-complement integral of the pulses |

## Verification
The reference is driven as a square wave with a half-period of a whole number of clocks. Some of these periods divide the DLY·M window exactly, which separates a true lock point from a half-step offset. Others are fractional or odd, such as 16/3 and 3 clocks, which give mixed correction patterns and expose errors in tap selection, delay length or capture latency. A constant reference shows that a frozen input gives a steady lower command. Long runs at both lock extremes drive ctrl_word into each saturation limit, and the reset that follows shows it returning to mid-scale.

// File: rtl/fld_pkg.sv
package fld_pkg;

    // Direction of a single correction
    typedef enum logic {
        DIR_LOWER = 1'b0,
        DIR_RAISE = 1'b1
    } fld_dir_e;

    // Pulse pair driven toward the tuning element
    typedef struct packed {
        logic up;
        logic down;
    } fld_pulse_t;

    function automatic fld_pulse_t dir_to_pulse(input fld_dir_e d);
        fld_pulse_t p;
        p.up   = (d == DIR_RAISE);
        p.down = (d == DIR_LOWER);
        return p;
    endfunction

    function automatic fld_dir_e compare_taps(input logic newest, input logic oldest);
        return fld_dir_e'(newest ^ oldest);
    endfunction

endpackage

// File: rtl/fld_strobe_div.sv
module fld_strobe_div #(
    parameter int DIV_STAGES = 3
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    logic [DIV_STAGES-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    // fires on the last count of each 2^DIV_STAGES cycle
    assign strobe = &div_cnt;
endmodule

// File: rtl/fld_sampler.sv
module fld_sampler #(
    parameter int SYNC_STAGES = 2,
    parameter int DLY         = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic ref_in,
    output logic tap_new,
    output logic tap_old
);
    localparam int TAPS = DLY + 1;

    logic cap_in;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign cap_in = ref_in;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= ref_in;
                    for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
                end
            end
            assign cap_in = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    // history[0] is the newest sample, history[DLY] the oldest
    logic [TAPS-1:0] history;

    always_ff @(posedge clk) begin
        if (rst)         history <= '0;
        else if (strobe) history <= {history[TAPS-2:0], cap_in};
    end

    assign tap_new = history[0];
    assign tap_old = history[DLY];
endmodule

// File: rtl/fld_corrector.sv
module fld_corrector
    import fld_pkg::*;
#(
    parameter int DLY = 7,
    parameter int CW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          tap_new,
    input  logic          tap_old,
    output logic          corr_bit,
    output logic          corr_valid,
    output fld_pulse_t    pulse,
    output logic [CW-1:0] ctrl_word
);
    localparam int                FILL_W    = $clog2(DLY + 2);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DLY + 1);
    localparam logic [CW-1:0]     CTRL_MAX  = {1'b0, {(CW-1){1'b1}}};
    localparam logic [CW-1:0]     CTRL_MIN  = {1'b1, {(CW-1){1'b0}}};
    localparam logic [CW-1:0]     ONE       = {{(CW-1){1'b0}}, 1'b1};

    logic [FILL_W-1:0] fill_q;
    logic              eval_q;
    logic [CW-1:0]     ctrl_q, ctrl_nx;
    fld_dir_e          dir;
    logic              hist_full;

    // count strobes until the history holds only post-reset samples
    always_ff @(posedge clk) begin
        if (rst)                              fill_q <= '0;
        else if (strobe && fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
    end

    // compare one clock after the shift, on the updated history
    always_ff @(posedge clk) begin
        if (rst) eval_q <= 1'b0;
        else     eval_q <= strobe;
    end

    assign hist_full = (fill_q == FILL_FULL);
    assign dir       = compare_taps(tap_new, tap_old);

    always_comb begin
        ctrl_nx = ctrl_q;
        if (dir == DIR_RAISE) begin
            if (ctrl_q != CTRL_MAX) ctrl_nx = ctrl_q + ONE;
        end else begin
            if (ctrl_q != CTRL_MIN) ctrl_nx = ctrl_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_bit   <= 1'b0;
            corr_valid <= 1'b0;
            pulse      <= '0;
            ctrl_q     <= '0;
        end else begin
            pulse <= '0;
            if (eval_q && hist_full) begin
                corr_valid <= 1'b1;
                corr_bit   <= dir;
                pulse      <= dir_to_pulse(dir);
                ctrl_q     <= ctrl_nx;
            end
        end
    end

    assign ctrl_word = ctrl_q;
endmodule

// File: rtl/fast_lock_discriminator.sv
module fast_lock_discriminator
    import fld_pkg::*;
#(
    parameter int DIV_STAGES  = 3,
    parameter int DLY         = 7,
    parameter int SYNC_STAGES = 2,
    parameter int CW          = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_in,
    output logic          corr_bit,
    output logic          corr_valid,
    output logic          up_pulse,
    output logic          down_pulse,
    output logic [CW-1:0] ctrl_word
);
    logic       strobe;
    logic       tap_new, tap_old;
    fld_pulse_t pulse;

    fld_strobe_div #(.DIV_STAGES(DIV_STAGES)) u_div (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe)
    );

    fld_sampler #(.SYNC_STAGES(SYNC_STAGES), .DLY(DLY)) u_smp (
        .clk     (clk),
        .rst     (rst),
        .strobe  (strobe),
        .ref_in  (ref_in),
        .tap_new (tap_new),
        .tap_old (tap_old)
    );

    fld_corrector #(.DLY(DLY), .CW(CW)) u_cor (
        .clk        (clk),
        .rst        (rst),
        .strobe     (strobe),
        .tap_new    (tap_new),
        .tap_old    (tap_old),
        .corr_bit   (corr_bit),
        .corr_valid (corr_valid),
        .pulse      (pulse),
        .ctrl_word  (ctrl_word)
    );

    assign up_pulse   = pulse.up;
    assign down_pulse = pulse.down;
endmodule

// File: rtl/fld_checker.sv
module fld_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          corr_bit,
    input logic          corr_valid,
    input logic          up_pulse,
    input logic          down_pulse,
    input logic [CW-1:0] ctrl_word
);
    localparam int MAXI = (2 ** (CW - 1)) - 1;
    localparam int MINI = -(2 ** (CW - 1));

    int cw_now;
    assign cw_now = int'($signed(ctrl_word));

    // R5
    pulse_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_pulse, down_pulse}));

    // R5
    up_single_chk: assert property (@(posedge clk) disable iff (rst)
        up_pulse |=> !up_pulse);

    // R4
    pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (up_pulse || down_pulse) |-> corr_valid);

    // R6
    ctrl_up_chk: assert property (@(posedge clk) disable iff (rst)
        up_pulse |-> ((cw_now == $past(cw_now) + 1) || (cw_now == MAXI && $past(cw_now) == MAXI)));

    // R6
    ctrl_down_chk: assert property (@(posedge clk) disable iff (rst)
        down_pulse |-> ((cw_now == $past(cw_now) - 1) || (cw_now == MINI && $past(cw_now) == MINI)));

    // R6
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_pulse && !down_pulse) |-> $stable(ctrl_word));

    // R3
    corr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_pulse && !down_pulse) |-> $stable(corr_bit));

    // R7
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (ctrl_word == '0 && !corr_valid && !corr_bit && !up_pulse && !down_pulse));
endmodule

bind fast_lock_discriminator fld_checker #(.CW(CW)) u_fld_chk (
    .clk        (clk),
    .rst        (rst),
    .corr_bit   (corr_bit),
    .corr_valid (corr_valid),
    .up_pulse   (up_pulse),
    .down_pulse (down_pulse),
    .ctrl_word  (ctrl_word)
);

// File: tb/sim_fast_lock_discriminator.sv
module sim_fast_lock_discriminator;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_STAGES = 3;
    localparam int M          = 2 ** DIV_STAGES;
    localparam int DLY        = 7;
    localparam int CW         = 8;
    localparam int CMAX       = (2 ** (CW - 1)) - 1;
    localparam int CMIN       = -(2 ** (CW - 1));

    // half-period of the reference = den/num clocks; kind 0 all-zero, 1 all-one, 2 mixed
    typedef struct packed {
        int num;
        int den;
        int nstr;
        int kind;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{1, 8, 140, 1},   // period 16: 56/16 = 3.5 -> all ones, saturate high
        '{1, 4, 140, 0},   // period 8: 56/8 = 7 -> lock, saturate low
        '{1, 7, 40, 0},    // period 14: 4 periods -> lock
        '{1, 28, 40, 0},   // period 56: 1 period -> lock
        '{3, 16, 60, 2},   // fractional half-period 16/3
        '{1, 3, 60, 2}     // period 6: not a lock point
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_in = 1'b0;
    logic          corr_bit, corr_valid, up_pulse, down_pulse;
    logic [CW-1:0] ctrl_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fast_lock_discriminator #(
        .DIV_STAGES (DIV_STAGES),
        .DLY        (DLY),
        .SYNC_STAGES(2),
        .CW         (CW)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .ref_in     (ref_in),
        .corr_bit   (corr_bit),
        .corr_valid (corr_valid),
        .up_pulse   (up_pulse),
        .down_pulse (down_pulse),
        .ctrl_word  (ctrl_word)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic refval(input int t, input int num, input int den);
        return logic'(((t * num) / den) & 1);
    endfunction

    task automatic do_reset();
        rst    = 1'b1;
        ref_in = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk("R7", "ctrl_word", int'($signed(ctrl_word)), 0);
        chk("R7", "corr_valid", int'(corr_valid), 0);
        chk("R7", "corr_bit", int'(corr_bit), 0);
        chk("R7", "pulses", int'({up_pulse, down_pulse}), 0);
        rst = 1'b0;
    endtask

    task automatic run_case(input int num, input int den, input int nstr, input int kind);
        logic smp [0:63];
        int   mctrl  = 0;
        logic mcorr  = 1'b0;
        logic mvalid = 1'b0;
        int   ones   = 0;
        int   zeros  = 0;
        int   seen   = 0;
        do_reset();
        for (int t = 1; t <= nstr * M + 1; t++) begin
            logic mup, mdn, c;
            int   j;
            ref_in = refval(t, num, den);
            @(posedge clk);
            @(negedge clk);
            mup = 1'b0;
            mdn = 1'b0;
            if (t > 1 && ((t - 1) % M) == 0) begin
                j = (t - 1) / M;
                // R2: capture is the level two edges before the strobe edge
                smp[j % 64] = refval(j * M - 2, num, den);
                if (j >= DLY + 1) begin
                    c      = smp[j % 64] ^ smp[(j - DLY) % 64];
                    mvalid = 1'b1;
                    mcorr  = c;
                    mup    = c;
                    mdn    = !c;
                    if (c) begin
                        ones++;
                        if (mctrl < CMAX) mctrl++;
                    end else begin
                        zeros++;
                        if (mctrl > CMIN) mctrl--;
                    end
                end
            end
            if (up_pulse || down_pulse) seen++;
            chk("R4", "corr_valid", int'(corr_valid), int'(mvalid));
            chk("R5", "up_pulse", int'(up_pulse), int'(mup));
            chk("R5", "down_pulse", int'(down_pulse), int'(mdn));
            chk("R2/R3", "corr_bit", int'(corr_bit), int'(mcorr));
            chk("R6", "ctrl_word", int'($signed(ctrl_word)), mctrl);
        end
        // R1: one pulse per valid strobe
        chk("R1", "pulse count", seen, nstr - DLY);
        // R8: lock and half-step patterns
        if (kind == 0) chk("R8", "raise count at lock", ones, 0);
        if (kind == 1) chk("R8", "lower count at half step", zeros, 0);
    endtask

    initial begin
        for (int v = 0; v < 6; v++) begin
            run_case(VECS[v].num, VECS[v].den, VECS[v].nstr, VECS[v].kind);
        end
        // saturation endpoints: previous runs ended at the limits
        run_case(1, 8, 140, 1);
        chk("R6", "upper limit", int'($signed(ctrl_word)), CMAX);
        run_case(0, 1, 140, 0);  // constant reference: steady lower command
        chk("R6", "lower limit", int'($signed(ctrl_word)), CMIN);
        do_reset();              // R7: reset from a saturated state
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule